// File: doc/BRIEF.md
# Framed Parallel-to-Serial Shifter

This block takes a parallel word and sends it out on a single serial line, one bit per clock, most significant bit first. A load input captures the word: while load is high the block keeps taking the data input, and the last word seen before load falls is the one sent. The output register presents the first bit at the first clock edge that samples load low after an edge that sampled it high.

A valid output stays high for every cycle that carries a serial bit. A frame output marks the cycle that carries the least significant bit, so a receiver can tell where one word ends without counting. Raising load again during a transmission abandons the rest of the word and captures a new one. Outside a transmission the serial line, valid and frame are all held low.

Top module: `ptos_framed_shifter`

## Requirements
- R1: While load is sampled high at a clock edge, the data input is captured; when load is held high for several cycles, the word present at the last such edge is the one transmitted.
- R2: At the first clock edge that samples load low after an edge that sampled it high, valid rises and the serial output shows bit WIDTH-1 of the captured word.
- R3: Bits leave in order from bit WIDTH-1 down to bit 0, one per clock.
- R4: One uninterrupted transmission keeps valid high for exactly WIDTH consecutive cycles, and valid is low in the cycle after the last bit.
- R5: Frame is high for exactly one cycle per completed word, the cycle in which bit 0 is on the serial output, and never while valid is low.
- R6: A clock edge that samples load high during a transmission ends it: in the next cycle valid, frame and the serial output are low, and the new word is then sent in full as in R2.
- R7: When no transmission is in progress, valid, frame and the serial output are 0.
- R8: Synchronous active-high reset clears the word register and the bit counter and drives valid, frame and the serial output to 0 in the next cycle, even mid-word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | High to capture the data input; its fall starts a transmission |
| din | input | WIDTH | Parallel word to send |
| sout | output | 1 | Serial bit, MSB first, 0 when idle |
| valid | output | 1 | High while sout carries a bit of the word |
| frame | output | 1 | High with the last (LSB) bit of a word |

## Verification
Two functions can coincide in one cycle: shifting the current word out and capturing a new one, when load rises while bits are still being sent. The bench provokes this by raising load with a different word partway through a transmission, and again right after a frame cycle. It judges the result by checking that valid falls the cycle after load is sampled, that the unsent bits of the abandoned word never appear, and that the new word then comes out whole, MSB first, with frame on its LSB. A reset mid-word is also treated as a collision with shifting and must silence every output in the next cycle.

// File: rtl/ptos_pkg.sv
package ptos_pkg;

  // Operation the sequencer requests from the word register each cycle.
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } shift_op_t;

  // Width of a counter that must reach the value n.
  function automatic int count_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ptos_word_reg.sv
module ptos_word_reg
  import ptos_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  shift_op_t        op,
  input  logic [WIDTH-1:0] din,
  output logic             sout_q
);

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sout_q <= 1'b0;
    end else begin
      case (op)
        OP_CAPTURE: begin
          word_q <= din;
          sout_q <= 1'b0;
        end
        OP_SHIFT: begin
          sout_q <= word_q[WIDTH-1];
          word_q <= word_q << 1;
        end
        default: begin
          sout_q <= 1'b0;
        end
      endcase
    end
  end

  // R1: a capture cycle leaves the sampled input word in the register
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CAPTURE) |=> (word_q == $past(din)));

  // R7: without a shift request the serial line returns to zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (op != OP_SHIFT) |=> !sout_q);

endmodule

// File: rtl/ptos_sequencer.sv
module ptos_sequencer
  import ptos_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  output shift_op_t op,
  output logic      valid_q,
  output logic      frame_q
);

  localparam int CW = count_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic          load_q;
  logic [CW-1:0] sent_q;
  logic [CW-1:0] sent_nx;
  logic          start;
  logic          more;
  logic          step;

  always_comb begin
    start   = load_q & ~load;
    more    = valid_q & (sent_q != LAST);
    step    = ~load & (start | more);
    sent_nx = start ? CW'(1) : sent_q + 1'b1;
    if (load)      op = OP_CAPTURE;
    else if (step) op = OP_SHIFT;
    else           op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= 1'b0;
      sent_q  <= '0;
      valid_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      load_q <= load;
      if (step) begin
        sent_q  <= sent_nx;
        valid_q <= 1'b1;
        frame_q <= (sent_nx == LAST);
      end else begin
        sent_q  <= '0;
        valid_q <= 1'b0;
        frame_q <= 1'b0;
      end
    end
  end

  // R4: the bit counter never runs past the word width
  p_sent_bound_r4: assert property (@(posedge clk) disable iff (rst)
    sent_q <= LAST);

  // R2: a falling load starts the first bit on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && $past(load) && !$past(rst)) |=> (valid_q && sent_q == CW'(1)));

  // R6: a sampled load kills valid in the following cycle
  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> !valid_q);

  // R4: the cycle after the last bit is never valid
  p_end_r4: assert property (@(posedge clk) disable iff (rst)
    frame_q |=> !valid_q);

endmodule

// File: rtl/ptos_framed_shifter.sv
module ptos_framed_shifter
  import ptos_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic             sout,
  output logic             valid,
  output logic             frame
);

  shift_op_t op;
  logic      valid_q;
  logic      frame_q;
  logic      sout_q;

  ptos_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .op      (op),
    .valid_q (valid_q),
    .frame_q (frame_q)
  );

  ptos_word_reg #(.WIDTH(WIDTH)) u_word (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .din    (din),
    .sout_q (sout_q)
  );

  assign sout  = sout_q;
  assign valid = valid_q;
  assign frame = frame_q;

  // R5: frame only accompanies a valid bit
  p_frame_valid_r5: assert property (@(posedge clk) disable iff (rst)
    frame |-> valid);

  // R7: idle outputs are all zero
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (!sout && !frame));

  // R8: reset silences every output on the next cycle
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!valid && !frame && !sout));

endmodule

// File: tb/ptos_framed_shifter_bench.sv
module ptos_framed_shifter_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] din = '0;
  logic         sout;
  logic         valid;
  logic         frame;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Expected serial items: {bit, frame}
  logic [1:0] expq[$];

  always #10 clk = ~clk;

  ptos_framed_shifter #(.WIDTH(W)) u_ptos_framed_shifter (
    .clk(clk), .rst(rst), .load(load), .din(din),
    .sout(sout), .valid(valid), .frame(frame)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) expq.push_back({w[i], (i == 0)});
  endtask

  // Monitor: compare every valid bit with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3", "unexpected valid bit", int'(sout), 0);
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        check(sout == e[1], "R3", "serial bit", int'(sout), int'(e[1]));
        check(frame == e[0], "R5", "frame", int'(frame), int'(e[0]));
      end
    end else if (!rst) begin
      check(!sout && !frame, "R7", "idle outputs", int'({sout, frame}), 0);
    end
  end

  // Drive load for hold cycles; the word of the last cycle is sent.
  task automatic start_word(input logic [W-1:0] w, input int hold);
    for (int k = 0; k < hold; k++) begin
      load = 1'b1;
      din  = (k == hold - 1) ? w : ~w;
      @(posedge clk); #2;
    end
    if (expq.size() != 0) expq.delete();
    push_word(w);
    load = 1'b0;
    din  = '0;
    @(negedge clk);
    check(!valid, "R6", "valid low after load edge", int'(valid), 0);
    @(posedge clk); #2;
    @(negedge clk);
    check(valid && sout == w[W-1], "R2", "first bit timing",
          int'({valid, sout}), int'({1'b1, w[W-1]}));
  endtask

  task automatic send(input logic [W-1:0] w, input int hold);
    start_word(w, hold);
    repeat (W) @(posedge clk);
    #2;
    @(negedge clk);
    check(!valid, "R4", "valid low after word", int'(valid), 0);
    check(expq.size() == 0, "R4", "bits left in scoreboard", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    check(!valid && !frame && !sout, "R8", "reset state",
          int'({valid, frame, sout}), 0);

    send(8'hA5, 1);
    send(8'h80, 1);
    send(8'h01, 1);
    send(8'hFF, 1);
    send(8'h00, 1);
    send(8'h3C, 4);   // R1: multi-cycle load keeps the last word

    // R6: abort mid-word, then send a new word in full
    start_word(8'hC3, 1);
    repeat (2) @(posedge clk);
    #2;
    load = 1'b1;
    din  = 8'h5A;
    @(posedge clk); #2;
    expq.delete();
    @(negedge clk);
    check(!valid && !frame && !sout, "R6", "abort silences outputs",
          int'({valid, frame, sout}), 0);
    load = 1'b0;
    push_word(8'h5A);
    repeat (W + 1) @(posedge clk);
    #2;
    @(negedge clk);
    check(expq.size() == 0, "R6", "new word after abort", expq.size(), 0);

    // R6: load right after a frame cycle
    send(8'h96, 1);
    send(8'h69, 1);

    // R8: reset mid-word
    start_word(8'hE7, 1);
    @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #2;
    expq.delete();
    @(negedge clk);
    check(!valid && !frame && !sout, "R8", "reset mid-word",
          int'({valid, frame, sout}), 0);
    rst = 1'b0;
    repeat (W + 2) @(posedge clk);
    #2;
    @(negedge clk);
    check(!valid, "R8", "stays idle after reset", int'(valid), 0);

    send(8'h4D, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule